// File: doc/BRIEF.md
# Paired Timer Count-Enable Selector

This block generates the count-enable strobes for two 8-bit up-counters that belong to one timer pair. Each channel has a 3-bit clock-source code. The code chooses one of five sources: no clock, one of three taps of a shared free-running prescaler, the partner channel's event, or an edge of that channel's own external clock pin. Every enable is exactly one system clock wide. The counter advances by one on each cycle in which its enable is high.

The counters, compare registers and interrupt logic sit outside this block. Two pulses come back in from them: the odd channel's overflow and the even channel's compare-match A. In cascade mode these pulses are forwarded as enables. If both channels choose cascade mode at the same time, the loop has no source and both enables stay low. A code change is held off for one cycle, so that no strobe can come from the timing of the source that was selected before.

Top module: `tmr_pair_cken`

## Requirements
- R1: Code 3'b000 gives no enable on that channel, whatever the pins, cascade pulses or prescaler do.
- R2: Code 3'b001 gives exactly one enable every 8 system clocks.
- R3: Code 3'b010 gives exactly one enable every 64 system clocks, and each of these enables falls in a cycle where the divide-by-8 tap also fires.
- R4: Code 3'b011 gives exactly one enable every 8192 system clocks.
- R5: Code 3'b100 (cascade) passes the source pulse through in the same cycle. The even channel uses `ovf_odd_i` and the odd channel uses `cmpa_even_i`. The other channel's source has no effect.
- R6: When both channels hold code 3'b100, neither enable is ever asserted.
- R7: Code 3'b110 gives one enable per rising edge of the channel's pin and none on falling edges. The enable appears in the second cycle after the pin changes, counted after the two-stage synchronizer.
- R8: Code 3'b101 gives one enable per falling edge of the pin and none on rising edges, with the same latency as R7.
- R9: Code 3'b111 gives one enable for each edge of the pin, rising or falling.
- R10: In the first cycle in which a channel's code differs from its value on the previous clock, that channel's enable is low.
- R11: During reset and right after it, both enables are low. The prescaler restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_even_i | input | 3 | Clock-source code, even channel |
| sel_odd_i | input | 3 | Clock-source code, odd channel |
| pin_even_i | input | 1 | External clock pin, even channel (asynchronous) |
| pin_odd_i | input | 1 | External clock pin, odd channel (asynchronous) |
| ovf_odd_i | input | 1 | Overflow pulse of the odd counter |
| cmpa_even_i | input | 1 | Compare-match A pulse of the even counter |
| cken_even_o | output | 1 | Count enable, even channel |
| cken_odd_o | output | 1 | Count enable, odd channel |

## Verification
Each prescaler code is measured by the gap between two consecutive strobes and by the number of strobes in a window. This tells the three division ratios apart, and it also separates a correct tap from a tap that fires for more than one cycle. The pins are driven with isolated rising and falling steps under each edge mode, and the pulse count and latency are checked. This shows that the edge polarity is decoded correctly and that the synchronizer depth is right. The cascade pulses are applied one at a time with the cascade code set on one channel, then on the other, then on both. This exposes swapped or crossed sources and a loop that is not blocked. A pin edge is also timed to land on the cycle in which the code changes, which shows that the one-cycle hold-off works.

// File: rtl/tmr_cken_pkg.sv
package tmr_cken_pkg;

  typedef enum logic [2:0] {
    CK_OFF      = 3'b000,
    CK_DIV_A    = 3'b001,
    CK_DIV_B    = 3'b010,
    CK_DIV_C    = 3'b011,
    CK_CASCADE  = 3'b100,
    CK_EXT_FALL = 3'b101,
    CK_EXT_RISE = 3'b110,
    CK_EXT_BOTH = 3'b111
  } ck_sel_e;

  typedef struct packed {
    logic fall;
    logic rise;
  } pin_edge_t;

  // Enable contributed by a pin event under a given code.
  function automatic logic pin_event_hit(input logic [2:0] code, input pin_edge_t ev);
    logic hit;
    case (code)
      CK_EXT_FALL: hit = ev.fall;
      CK_EXT_RISE: hit = ev.rise;
      CK_EXT_BOTH: hit = ev.fall | ev.rise;
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_A_LOG = 3,
  parameter int DIV_B_LOG = 6,
  parameter int DIV_C_LOG = 13,
  localparam int CNT_W = DIV_C_LOG
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_a_o,
  output logic tick_b_o,
  output logic tick_c_o
);

  logic [CNT_W-1:0] cnt_q;

  // True when the lowest n bits are all ones, so the next edge rolls them to zero.
  function automatic logic low_bits_full(input logic [CNT_W-1:0] v, input int n);
    logic r;
    r = 1'b1;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < n) r = r & v[i];
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_a_o = low_bits_full(cnt_q, DIV_A_LOG);
  assign tick_b_o = low_bits_full(cnt_q, DIV_B_LOG);
  assign tick_c_o = low_bits_full(cnt_q, DIV_C_LOG);

  p_tap_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_a_o |=> !tick_a_o);
  p_tap_nest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_b_o |-> tick_a_o);
  p_tap_nest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_c_o |-> tick_b_o);

endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge
  import tmr_cken_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  output pin_edge_t ev_o
);

  // Stages [SYNC_STAGES-1:0] synchronize; the top stage holds the previous level.
  logic [SYNC_STAGES:0] sh_q;
  logic                 level_now;
  logic                 level_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  assign level_now = sh_q[SYNC_STAGES-1];
  assign level_old = sh_q[SYNC_STAGES];
  assign ev_o.rise = level_now & ~level_old;
  assign ev_o.fall = ~level_now & level_old;

  p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o.rise |=> !ev_o.rise);
  p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o.fall |=> !ev_o.fall);
  p_edge_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_o.rise && ev_o.fall));

endmodule

// File: rtl/tmr_chan_sel.sv
module tmr_chan_sel
  import tmr_cken_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  input  logic       tick_a_i,
  input  logic       tick_b_i,
  input  logic       tick_c_i,
  input  logic       cascade_src_i,
  input  logic       cascade_block_i,
  input  pin_edge_t  ev_i,
  output logic       cken_o
);

  logic [2:0] sel_q;
  logic       sel_settled;
  logic       src_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= CK_OFF;
    else        sel_q <= sel_i;
  end

  assign sel_settled = (sel_i == sel_q);

  always_comb begin
    case (sel_i)
      CK_OFF:     src_hit = 1'b0;
      CK_DIV_A:   src_hit = tick_a_i;
      CK_DIV_B:   src_hit = tick_b_i;
      CK_DIV_C:   src_hit = tick_c_i;
      CK_CASCADE: src_hit = cascade_src_i & ~cascade_block_i;
      default:    src_hit = pin_event_hit(sel_i, ev_i);
    endcase
  end

  assign cken_o = sel_settled & src_hit;

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == CK_OFF) |-> !cken_o);
  p_cascade_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cken_o && sel_i == CK_CASCADE) |-> cascade_src_i);
  p_new_code_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i != $past(sel_i)) |-> !cken_o);

endmodule

// File: rtl/tmr_pair_cken.sv
module tmr_pair_cken
  import tmr_cken_pkg::*;
#(
  parameter int DIV_A_LOG   = 3,
  parameter int DIV_B_LOG   = 6,
  parameter int DIV_C_LOG   = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_even_i,
  input  logic [2:0] sel_odd_i,
  input  logic       pin_even_i,
  input  logic       pin_odd_i,
  input  logic       ovf_odd_i,
  input  logic       cmpa_even_i,
  output logic       cken_even_o,
  output logic       cken_odd_o
);

  localparam int NCH = 2;

  logic             tick_a, tick_b, tick_c;
  logic             loop_dead;
  logic [2:0]       sel_ch   [NCH];
  logic [NCH-1:0]   pin_ch;
  logic [NCH-1:0]   casc_ch;
  logic [NCH-1:0]   cken_ch;
  pin_edge_t        ev_ch    [NCH];

  assign sel_ch[0]  = sel_even_i;
  assign sel_ch[1]  = sel_odd_i;
  assign pin_ch     = {pin_odd_i, pin_even_i};
  // Asymmetric cascade: even follows odd overflow, odd follows even compare-match A.
  assign casc_ch    = {cmpa_even_i, ovf_odd_i};
  assign loop_dead  = (sel_even_i == CK_CASCADE) && (sel_odd_i == CK_CASCADE);

  tmr_prescaler #(
    .DIV_A_LOG(DIV_A_LOG),
    .DIV_B_LOG(DIV_B_LOG),
    .DIV_C_LOG(DIV_C_LOG)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_a_o(tick_a),
    .tick_b_o(tick_b),
    .tick_c_o(tick_c)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tmr_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_i(pin_ch[ch]),
      .ev_o (ev_ch[ch])
    );

    tmr_chan_sel u_sel (
      .clk            (clk),
      .rst_n          (rst_n),
      .sel_i          (sel_ch[ch]),
      .tick_a_i       (tick_a),
      .tick_b_i       (tick_b),
      .tick_c_i       (tick_c),
      .cascade_src_i  (casc_ch[ch]),
      .cascade_block_i(loop_dead),
      .ev_i           (ev_ch[ch]),
      .cken_o         (cken_ch[ch])
    );
  end

  assign cken_even_o = cken_ch[0];
  assign cken_odd_o  = cken_ch[1];

  p_loop_dead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_dead |-> (!cken_even_o && !cken_odd_o));
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_n |-> (!cken_even_o && !cken_odd_o));

endmodule

// File: tb/tmr_pair_cken_tb.sv
`timescale 1ns/1ps
module tmr_pair_cken_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel_even = 3'b000, sel_odd = 3'b000;
  logic       pin_even = 1'b0, pin_odd = 1'b0;
  logic       ovf_odd = 1'b0, cmpa_even = 1'b0;
  logic       cken_even, cken_odd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tmr_pair_cken u_dut (
    .clk(clk), .rst_n(rst_n),
    .sel_even_i(sel_even), .sel_odd_i(sel_odd),
    .pin_even_i(pin_even), .pin_odd_i(pin_odd),
    .ovf_odd_i(ovf_odd), .cmpa_even_i(cmpa_even),
    .cken_even_o(cken_even), .cken_odd_o(cken_odd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit ck(input bit odd);
    return odd ? cken_odd : cken_even;
  endfunction

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count enables on one channel over n cycles, sampled at falling edges.
  task automatic count_pulses(input bit odd, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #0.1;
      if (ck(odd)) cnt++;
    end
  endtask

  // Gap in cycles between two consecutive enables on one channel.
  task automatic measure_gap(input bit odd, input int limit, output int gap);
    int i;
    gap = -1;
    i = 0;
    do begin @(negedge clk); #0.1; i++; end while (!ck(odd) && i < limit);
    if (i >= limit) return;
    i = 0;
    do begin @(negedge clk); #0.1; i++; end while (!ck(odd) && i < limit);
    if (i < limit) gap = i;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    settle(3);
    chk("R11 even quiet in reset", cken_even, 0);
    chk("R11 odd quiet in reset", cken_odd, 0);
    rst_n = 1'b1;
    sel_even = 3'b001;
    settle(2);
    // Counter restarted at 0 on release; all-ones low bits first seen 7 cycles later.
    begin
      int gap;
      measure_gap(0, 20, gap);
      chk("R11 div8 after reset", gap, 8);
    end
    sel_even = 3'b000;
    settle(2);
  endtask

  task automatic t_off();
    int c0, c1;
    sel_even = 3'b000; sel_odd = 3'b000;
    settle(2);
    fork
      count_pulses(0, 100, c0);
      count_pulses(1, 100, c1);
      begin
        for (int i = 0; i < 20; i++) begin
          @(negedge clk); pin_even = ~pin_even; pin_odd = ~pin_odd;
          ovf_odd = 1'b1; cmpa_even = 1'b1;
          @(negedge clk); ovf_odd = 1'b0; cmpa_even = 1'b0;
          settle(2);
        end
      end
    join
    chk("R1 even off", c0, 0);
    chk("R1 odd off", c1, 0);
    pin_even = 1'b0; pin_odd = 1'b0;
    settle(4);
  endtask

  task automatic t_div();
    int g, c;
    sel_even = 3'b001; sel_odd = 3'b010;
    settle(2);
    measure_gap(0, 20, g);
    chk("R2 div8 gap even", g, 8);
    count_pulses(0, 80, c);
    chk("R2 div8 window count", c, 10);
    measure_gap(1, 150, g);
    chk("R3 div64 gap odd", g, 64);
    count_pulses(1, 640, c);
    chk("R3 div64 window count", c, 10);
    sel_odd = 3'b011;
    settle(2);
    measure_gap(1, 9000, g);
    chk("R4 div8192 gap odd", g, 8192);
    sel_even = 3'b000; sel_odd = 3'b000;
    settle(2);
  endtask

  task automatic pulse_src(input bit use_ovf, output bit e, output bit o);
    @(negedge clk);
    if (use_ovf) ovf_odd = 1'b1; else cmpa_even = 1'b1;
    #0.1;
    e = cken_even; o = cken_odd;
    @(negedge clk);
    ovf_odd = 1'b0; cmpa_even = 1'b0;
  endtask

  task automatic t_cascade();
    bit e, o;
    sel_even = 3'b100; sel_odd = 3'b000;
    settle(2);
    pulse_src(1, e, o);
    chk("R5 even follows odd overflow", e, 1);
    pulse_src(0, e, o);
    chk("R5 even ignores compare-match", e, 0);
    sel_even = 3'b000; sel_odd = 3'b100;
    settle(2);
    pulse_src(0, e, o);
    chk("R5 odd follows even compare-match", o, 1);
    pulse_src(1, e, o);
    chk("R5 odd ignores overflow", o, 0);
    sel_even = 3'b100; sel_odd = 3'b100;
    settle(2);
    pulse_src(1, e, o);
    chk("R6 loop even blocked", e, 0);
    pulse_src(0, e, o);
    chk("R6 loop odd blocked", o, 0);
    sel_even = 3'b000; sel_odd = 3'b000;
    settle(2);
  endtask

  // Step the pin to 'lvl' and watch six cycles: count enables and first one's position.
  task automatic ext_step(input bit odd, input bit lvl, output int cnt, output int first);
    cnt = 0; first = -1;
    if (odd) pin_odd = lvl; else pin_even = lvl;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk); #0.1;
      if (ck(odd)) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
  endtask

  task automatic t_ext();
    int c, f;
    sel_odd = 3'b110;
    settle(4);
    ext_step(1, 1, c, f);
    chk("R7 rise one pulse", c, 1);
    chk("R7 rise latency", f, 2);
    ext_step(1, 0, c, f);
    chk("R7 fall ignored", c, 0);
    sel_odd = 3'b101;
    settle(4);
    ext_step(1, 1, c, f);
    chk("R8 rise ignored", c, 0);
    ext_step(1, 0, c, f);
    chk("R8 fall one pulse", c, 1);
    chk("R8 fall latency", f, 2);
    sel_even = 3'b111;
    settle(4);
    ext_step(0, 1, c, f);
    chk("R9 both rise", c, 1);
    ext_step(0, 0, c, f);
    chk("R9 both fall", c, 1);
    sel_even = 3'b000; sel_odd = 3'b000;
    settle(2);
  endtask

  task automatic t_sel_change();
    int c;
    sel_even = 3'b000;
    settle(4);
    @(negedge clk); pin_even = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // Detected rise is present in this cycle; the code switches now.
    sel_even = 3'b110;
    #0.1;
    chk("R10 switch cycle quiet", cken_even, 0);
    count_pulses(0, 5, c);
    chk("R10 no stale edge", c, 0);
    pin_even = 1'b0;
    sel_even = 3'b000;
    settle(4);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_off();
    t_div();
    t_cascade();
    t_ext();
    t_sel_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule